// File: doc/BRIEF.md
# SD Card SPI-Mode Command Engine

This block carries out one complete SD-card command transaction in SPI mode. A host hands it a 6-bit command index, a 32-bit argument, a flag that marks an application-specific command, and the kind of answer the card will give. The engine selects the card and waits for it to be ready. It sends the application prefix command when one is needed, then frames and shifts out the six-byte command packet. It hunts for the status byte among the fill bytes and picks up any trailing answer bytes. For commands that answer with busy, it waits until the card lets go of the line.

The engine does not serialize bits itself. It works through a byte-exchange port: it holds a request with the byte to send, and a serializer returns one received byte together with a single-cycle acknowledge. At the end of a command the engine reports the status byte, a 32-bit extended answer and a small error code. For commands that open a data phase, it leaves the card selected.

Top module: `sd_cmd_engine`

## Requirements
- R1: The first packet byte is 0x40 OR the command index, and the next four bytes carry the argument, most significant byte first.
- R2: The sixth packet byte is 0x95 for command 0, 0x87 for command 8 and 0xFF for every other command (the prefix command included).
- R3: After the packet, the engine sends 0xFF fill bytes and takes the first received byte whose bit 7 is 0 as the status byte. It sends at most POLL_MAX (16) such fill bytes, and the last one it receives stands as the status byte.
- R4: For command 12 there is no ready-wait before the packet, and the one byte received right after the packet is discarded before polling starts.
- R5: If the status byte is 0xFF, the whole command is sent again, together with its prefix. After ATTEMPTS (3) attempts in total the engine ends with error 1 and status 0xFF.
- R6: An application command (app flag 1) is preceded by command 55 with argument 0, a status poll, and a ready-wait. A retried command repeats all of them.
- R7: Errors are decided in this priority order: status bit 3 gives error 2, bit 2 gives error 3, bit 1 or 4 gives error 4, and bit 5 or 6 gives error 5. Bit 0 gives no error, and no flagged bit gives error 0. Errors 2 and 3 end the command without reading trailing bytes.
- R8: Response type 2 (long) reads four more bytes into the extended answer, most significant first. Type 3 reads one byte into bits 7:0. Types 0 and 1 leave the extended answer at 0.
- R9: Response type 1 (busy) keeps sending 0xFF until 0xFF is received.
- R10: Except for command 12, every command starts by selecting the card and exchanging 0xFF until 0xFF is received. If this wait, or the busy wait, lasts past CYC_PER_MS*TIMEOUT_MS cycles, the command ends with error 6 (status unchanged).
- R11: After error 0 on command 9, 17, 18, 24 or 25 (app flag 0), or on command 22 (app flag 1), chip select stays low and no trailing byte is sent. Otherwise chip select goes high and one trailing 0xFF byte is exchanged before done.
- R12: Once the engine raises the exchange request, it holds the request and its byte steady until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Start a command (taken when cmd_ready is 1) |
| cmd_ready | output | 1 | Engine idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_app | input | 1 | Application command: send prefix 55 first |
| cmd_rtype | input | 2 | 0 plain, 1 busy, 2 long (4 bytes), 3 short extra byte |
| done | output | 1 | One-cycle pulse at the end of the command |
| resp_r1 | output | 8 | Status byte (0xFF if none) |
| resp_ext | output | 32 | Extended answer |
| resp_err | output | 3 | 0 ok, 1 no card, 2 CRC, 3 illegal, 4 erase, 5 address/parameter, 6 timeout |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_req | output | 1 | Byte exchange request |
| spi_tx | output | 8 | Byte to send |
| spi_ack | input | 1 | Exchange complete, spi_rx valid |
| spi_rx | input | 8 | Byte received |

## Verification
The bench places a stuff byte with bit 7 clear after command 12. A design that failed to discard it would report an illegal-command error. It also sets up a status byte on the last allowed poll and another one poll too late. A design with an off-by-one poll limit would lose the first or accept the second. A run with no card at all checks that exactly three packets are sent, and an application command whose first attempt goes unanswered checks that the prefix goes out twice. Status bytes with several error bits set at once expose a wrong priority order. A status byte followed by a long answer that must not be read shows whether a CRC or illegal error stops early. Cases that must keep chip select low, and one that must release it, show a wrong hold decision at the port.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [2:0] {
    E_OK      = 3'd0,
    E_NODEV   = 3'd1,
    E_CRC     = 3'd2,
    E_ILLEGAL = 3'd3,
    E_ERASE   = 3'd4,
    E_PARAM   = 3'd5,
    E_TIMEOUT = 3'd6
  } sd_err_e;

  typedef enum logic [1:0] {
    RT_PLAIN = 2'd0,
    RT_BUSY  = 2'd1,
    RT_LONG  = 2'd2,
    RT_SHORT = 2'd3
  } sd_rtype_e;

  typedef enum logic [2:0] {
    S_IDLE, S_READY, S_SEND, S_STUFF, S_POLL, S_EXT, S_BUSY, S_REL
  } sd_state_e;

  localparam logic [5:0] IDX_RESET  = 6'd0;
  localparam logic [5:0] IDX_IFCOND = 6'd8;
  localparam logic [5:0] IDX_STOP   = 6'd12;
  localparam logic [5:0] IDX_APP    = 6'd55;
  localparam logic [7:0] FILL       = 8'hFF;

  function automatic logic [7:0] end_byte(logic [5:0] idx);
    case (idx)
      IDX_RESET:  return 8'h95;
      IDX_IFCOND: return 8'h87;
      default:    return 8'hFF;
    endcase
  endfunction

  function automatic logic keeps_select(logic [5:0] idx, logic app);
    if (app) return (idx == 6'd22);
    return (idx == 6'd9) || (idx == 6'd17) || (idx == 6'd18) ||
           (idx == 6'd24) || (idx == 6'd25);
  endfunction

  function automatic sd_err_e classify_status(logic [7:0] s);
    if (s[3])              return E_CRC;
    else if (s[2])         return E_ILLEGAL;
    else if (s[1] || s[4]) return E_ERASE;
    else if (s[5] || s[6]) return E_PARAM;
    return E_OK;
  endfunction

endpackage

// File: rtl/sd_cmd_framer.sv
module sd_cmd_framer
  import sd_cmd_pkg::*;
(
  input  logic [5:0]  idx,
  input  logic [31:0] arg,
  input  logic [2:0]  sel,
  output logic [7:0]  byte_o
);
  always_comb begin
    case (sel)
      3'd0:    byte_o = {2'b01, idx};
      3'd1:    byte_o = arg[31:24];
      3'd2:    byte_o = arg[23:16];
      3'd3:    byte_o = arg[15:8];
      3'd4:    byte_o = arg[7:0];
      3'd5:    byte_o = end_byte(idx);
      default: byte_o = FILL;
    endcase
  end
endmodule

// File: rtl/sd_status_decode.sv
module sd_status_decode
  import sd_cmd_pkg::*;
(
  input  logic [7:0] status,
  output sd_err_e    err,
  output logic       fatal
);
  always_comb begin
    err   = classify_status(status);
    fatal = (err == E_CRC) || (err == E_ILLEGAL);
  end
endmodule

// File: rtl/sd_wait_timer.sv
module sd_wait_timer #(
  parameter longint unsigned LIMIT = 64'd1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q >= CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  p_timer_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && expired) |=> (expired || !$past(run)));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int CYC_PER_MS = 250000,
  parameter int TIMEOUT_MS = 5000,
  parameter int POLL_MAX   = 16,
  parameter int ATTEMPTS   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        cmd_app,
  input  logic [1:0]  cmd_rtype,
  output logic        done,
  output logic [7:0]  resp_r1,
  output logic [31:0] resp_ext,
  output logic [2:0]  resp_err,
  output logic        spi_cs_n,
  output logic        spi_req,
  output logic [7:0]  spi_tx,
  input  logic        spi_ack,
  input  logic [7:0]  spi_rx
);
  localparam longint unsigned TMO_CYC = longint'(CYC_PER_MS) * longint'(TIMEOUT_MS);
  localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam int AW = (ATTEMPTS > 1) ? $clog2(ATTEMPTS) : 1;

  sd_state_e   st;
  logic [5:0]  idx_q;
  logic [31:0] arg_q;
  logic        app_q, pre_q, post_app_q;
  sd_rtype_e   rt_q;
  logic [2:0]  byte_q;
  logic [PW-1:0] poll_q;
  logic [AW-1:0] try_q;
  logic [2:0]  ext_left;
  logic [7:0]  r1_q;
  logic [31:0] ext_q;
  sd_err_e     err_q;
  logic        cs_n_q, done_q;

  // named internal events
  logic [5:0]  cur_idx;
  logic [31:0] cur_arg;
  logic [7:0]  pkt_byte;
  sd_err_e     rx_err;
  logic        rx_fatal;
  logic        tmr_run, tmr_exp;
  logic        hold_sel;
  logic        status_seen;
  logic        last_poll;

  assign cur_idx     = pre_q ? IDX_APP : idx_q;
  assign cur_arg     = pre_q ? 32'd0 : arg_q;
  assign tmr_run     = (st == S_READY) || (st == S_BUSY);
  assign hold_sel    = keeps_select(idx_q, app_q);
  assign last_poll   = (poll_q == PW'(POLL_MAX - 1));
  assign status_seen = spi_ack && (st == S_POLL) && (!spi_rx[7] || last_poll);

  sd_cmd_framer u_framer (
    .idx(cur_idx), .arg(cur_arg), .sel(byte_q), .byte_o(pkt_byte)
  );

  sd_status_decode u_decode (
    .status(spi_rx), .err(rx_err), .fatal(rx_fatal)
  );

  sd_wait_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_exp)
  );

  assign cmd_ready = (st == S_IDLE);
  assign spi_req   = (st != S_IDLE);
  assign spi_tx    = (st == S_SEND) ? pkt_byte : FILL;
  assign spi_cs_n  = cs_n_q;
  assign done      = done_q;
  assign resp_r1   = r1_q;
  assign resp_ext  = ext_q;
  assign resp_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx_q <= '0; arg_q <= '0; app_q <= 1'b0; rt_q <= RT_PLAIN;
      pre_q <= 1'b0; post_app_q <= 1'b0;
      byte_q <= '0; poll_q <= '0; try_q <= '0; ext_left <= '0;
      r1_q <= FILL; ext_q <= '0; err_q <= E_OK;
      cs_n_q <= 1'b1; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          idx_q <= cmd_idx; arg_q <= cmd_arg; app_q <= cmd_app;
          rt_q <= sd_rtype_e'(cmd_rtype);
          cs_n_q <= 1'b0; err_q <= E_OK; r1_q <= FILL; ext_q <= '0;
          try_q <= '0; post_app_q <= 1'b0; byte_q <= '0; pre_q <= cmd_app;
          st <= (cmd_idx == IDX_STOP) ? S_SEND : S_READY;
        end
        S_READY: if (spi_ack) begin
          if (spi_rx == FILL) begin
            byte_q <= '0;
            pre_q <= post_app_q ? 1'b0 : app_q;
            post_app_q <= 1'b0;
            st <= S_SEND;
          end else if (tmr_exp) begin
            err_q <= E_TIMEOUT; cs_n_q <= 1'b1; st <= S_REL;
          end
        end
        S_SEND: if (spi_ack) begin
          if (byte_q == 3'd5) begin
            poll_q <= '0;
            st <= (!pre_q && idx_q == IDX_STOP) ? S_STUFF : S_POLL;
          end else begin
            byte_q <= byte_q + 3'd1;
          end
        end
        S_STUFF: if (spi_ack) st <= S_POLL;
        S_POLL: if (spi_ack) begin
          if (status_seen) begin
            if (pre_q) begin
              post_app_q <= 1'b1; st <= S_READY;
            end else begin
              r1_q <= spi_rx;
              if (spi_rx == FILL) begin
                if (try_q == AW'(ATTEMPTS - 1)) begin
                  err_q <= E_NODEV; cs_n_q <= 1'b1; st <= S_REL;
                end else begin
                  try_q <= try_q + 1'b1; pre_q <= app_q; byte_q <= '0; st <= S_SEND;
                end
              end else begin
                err_q <= rx_err;
                if (rx_fatal) begin
                  cs_n_q <= 1'b1; st <= S_REL;
                end else begin
                  case (rt_q)
                    RT_LONG:  begin ext_left <= 3'd4; st <= S_EXT; end
                    RT_SHORT: begin ext_left <= 3'd1; st <= S_EXT; end
                    RT_BUSY:  st <= S_BUSY;
                    default: begin
                      if (rx_err == E_OK && hold_sel) begin st <= S_IDLE; done_q <= 1'b1; end
                      else begin cs_n_q <= 1'b1; st <= S_REL; end
                    end
                  endcase
                end
              end
            end
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        S_EXT: if (spi_ack) begin
          ext_q <= {ext_q[23:0], spi_rx};
          ext_left <= ext_left - 3'd1;
          if (ext_left == 3'd1) begin
            if (err_q == E_OK && hold_sel) begin st <= S_IDLE; done_q <= 1'b1; end
            else begin cs_n_q <= 1'b1; st <= S_REL; end
          end
        end
        S_BUSY: if (spi_ack) begin
          if (spi_rx == FILL) begin
            if (err_q == E_OK && hold_sel) begin st <= S_IDLE; done_q <= 1'b1; end
            else begin cs_n_q <= 1'b1; st <= S_REL; end
          end else if (tmr_exp) begin
            err_q <= E_TIMEOUT; cs_n_q <= 1'b1; st <= S_REL;
          end
        end
        S_REL: if (spi_ack) begin
          st <= S_IDLE; done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req && !spi_ack) |=> (spi_req && $stable(spi_tx)));

  p_cs_in_packet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND) |-> !spi_cs_n);

  p_cs_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REL) |-> spi_cs_n);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_attempt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    try_q <= AW'(ATTEMPTS - 1));

  p_nodev_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp_err == E_NODEV) |-> (resp_r1 == FILL));
endmodule

// File: tb/sd_cmd_engine_tb_top.sv
module sd_cmd_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_app = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic [1:0]  cmd_rtype = '0;
  logic        cmd_ready, done, spi_cs_n, spi_req;
  logic [7:0]  resp_r1, spi_tx;
  logic [31:0] resp_ext;
  logic [2:0]  resp_err;
  logic        spi_ack = 1'b0;
  logic [7:0]  spi_rx = 8'hFF;

  sd_cmd_engine #(.CYC_PER_MS(10), .TIMEOUT_MS(5), .POLL_MAX(16), .ATTEMPTS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_app(cmd_app), .cmd_rtype(cmd_rtype),
    .done(done), .resp_r1(resp_r1), .resp_ext(resp_ext), .resp_err(resp_err),
    .spi_cs_n(spi_cs_n), .spi_req(spi_req), .spi_tx(spi_tx),
    .spi_ack(spi_ack), .spi_rx(spi_rx)
  );

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0]  r1;
    logic [31:0] ext;
    logic [2:0]  err;
    logic        cs_n;
    string       tag;
  } exp_t;

  exp_t expq[$];
  logic [7:0] rxq[$];
  logic [7:0] txlog[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // card model: one byte per request, scripted replies, 0xFF when script empty
  initial begin
    forever begin
      @(negedge clk);
      spi_ack = 1'b0;
      if (rst_n && spi_req) begin
        logic [7:0] cap;
        cap = spi_tx;
        txlog.push_back(cap);
        @(negedge clk);
        chk(spi_req && spi_tx == cap, "R12 request/byte held", {23'd0, spi_req, spi_tx}, {24'd1, cap});
        spi_rx = (rxq.size() > 0) ? rxq.pop_front() : 8'hFF;
        spi_ack = 1'b1;
      end
    end
  end

  // monitor: scoreboard compare at the done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (expq.size() == 0) begin
          chk(1'b0, "scoreboard empty at done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(resp_r1 == e.r1,     {e.tag, " status"}, {24'd0, resp_r1}, {24'd0, e.r1});
          chk(resp_ext == e.ext,   {e.tag, " ext"},    resp_ext, e.ext);
          chk(resp_err == e.err,   {e.tag, " err"},    {29'd0, resp_err}, {29'd0, e.err});
          chk(spi_cs_n == e.cs_n,  {e.tag, " R11 cs"}, {31'd0, spi_cs_n}, {31'd0, e.cs_n});
        end
      end
    end
  end

  task automatic new_test();
    rxq.delete();
    txlog.delete();
  endtask

  task automatic push_n(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) rxq.push_back(v);
  endtask

  function automatic int count_tx(input logic [7:0] v);
    int c = 0;
    foreach (txlog[i]) if (txlog[i] == v) c++;
    return c;
  endfunction

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic app,
                         input logic [1:0] rt, input logic [7:0] er1, input logic [31:0] eext,
                         input logic [2:0] eerr, input logic ecs, input string tag);
    exp_t e;
    e.r1 = er1; e.ext = eext; e.err = eerr; e.cs_n = ecs; e.tag = tag;
    expq.push_back(e);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; cmd_app = app; cmd_rtype = rt; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && spi_cs_n && !spi_req && !done, "reset state",
        {28'd0, cmd_ready, spi_cs_n, spi_req, done}, 32'b1100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // CMD0: framing, reset end byte
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h01);
    run_cmd(6'd0, 32'h0, 1'b0, 2'd0, 8'h01, 32'h0, 3'd0, 1'b1, "R3 cmd0");
    chk(txlog[0] == 8'hFF, "R10 ready byte first", {24'd0, txlog[0]}, 32'hFF);
    chk(txlog[1] == 8'h40, "R1 header cmd0", {24'd0, txlog[1]}, 32'h40);
    chk(txlog[6] == 8'h95, "R2 end byte cmd0", {24'd0, txlog[6]}, 32'h95);
    chk(txlog.size() == 9, "R11 one trailing byte", txlog.size(), 32'd9);

    // CMD8: long answer after two fill polls
    new_test(); push_n(8'hFF, 9); rxq.push_back(8'h01);
    rxq.push_back(8'h00); rxq.push_back(8'h00); rxq.push_back(8'h01); rxq.push_back(8'hAA);
    run_cmd(6'd8, 32'h000001AA, 1'b0, 2'd2, 8'h01, 32'h000001AA, 3'd0, 1'b1, "R8 cmd8 long");
    chk(txlog[1] == 8'h48 && txlog[4] == 8'h01 && txlog[5] == 8'hAA, "R1 arg msb first",
        {txlog[1], txlog[4], txlog[5], 8'h0}, 32'h4801AA00);
    chk(txlog[6] == 8'h87, "R2 end byte cmd8", {24'd0, txlog[6]}, 32'h87);

    // ACMD41 with prefix
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h01); push_n(8'hFF, 7); rxq.push_back(8'h00);
    run_cmd(6'd41, 32'h40000000, 1'b1, 2'd0, 8'h00, 32'h0, 3'd0, 1'b1, "R6 acmd41");
    chk(txlog[1] == 8'h77 && txlog[6] == 8'hFF, "R6 prefix packet", {txlog[1], txlog[6]}, 16'h77FF);
    chk(txlog[9] == 8'h69 && txlog[10] == 8'h40, "R6 main after ready-wait", {txlog[9], txlog[10]}, 16'h6940);

    // no card: three attempts
    new_test();
    run_cmd(6'd16, 32'h200, 1'b0, 2'd0, 8'hFF, 32'h0, 3'd1, 1'b1, "R5 no card");
    chk(count_tx(8'h50) == 3, "R5 three packets", count_tx(8'h50), 32'd3);

    // app command retried with its prefix
    new_test(); push_n(8'hFF, 52); rxq.push_back(8'h01); push_n(8'hFF, 7); rxq.push_back(8'h00);
    run_cmd(6'd23, 32'h4, 1'b1, 2'd0, 8'h00, 32'h0, 3'd0, 1'b1, "R5 app retry");
    chk(count_tx(8'h77) == 2, "R6 prefix resent on retry", count_tx(8'h77), 32'd2);

    // CMD12 stuff byte and busy
    new_test(); push_n(8'hFF, 6); rxq.push_back(8'h04); rxq.push_back(8'h00);
    push_n(8'h00, 3); rxq.push_back(8'hFF);
    run_cmd(6'd12, 32'h0, 1'b0, 2'd1, 8'h00, 32'h0, 3'd0, 1'b1, "R4 stop stuff");
    chk(txlog[0] == 8'h4C, "R4 no ready-wait", {24'd0, txlog[0]}, 32'h4C);
    chk(txlog.size() == 13, "R9 busy bytes", txlog.size(), 32'd13);

    // fatal status stops early
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h05);
    rxq.push_back(8'h12); rxq.push_back(8'h34); rxq.push_back(8'h56); rxq.push_back(8'h78);
    run_cmd(6'd58, 32'h0, 1'b0, 2'd2, 8'h05, 32'h0, 3'd3, 1'b1, "R7 illegal no trailing");
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h0D);
    run_cmd(6'd16, 32'h200, 1'b0, 2'd0, 8'h0D, 32'h0, 3'd2, 1'b1, "R7 crc over illegal");
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h22);
    run_cmd(6'd16, 32'h200, 1'b0, 2'd0, 8'h22, 32'h0, 3'd4, 1'b1, "R7 erase over address");
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h40);
    run_cmd(6'd16, 32'h200, 1'b0, 2'd0, 8'h40, 32'h0, 3'd5, 1'b1, "R7 parameter");

    // data-phase commands keep select
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h00);
    run_cmd(6'd17, 32'h1000, 1'b0, 2'd0, 8'h00, 32'h0, 3'd0, 1'b0, "R11 read keeps cs");
    chk(txlog.size() == 8, "R11 no trailing on hold", txlog.size(), 32'd8);
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h20);
    run_cmd(6'd24, 32'h1000, 1'b0, 2'd0, 8'h20, 32'h0, 3'd5, 1'b1, "R11 write error releases");
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h00); push_n(8'hFF, 7); rxq.push_back(8'h00);
    run_cmd(6'd22, 32'h0, 1'b1, 2'd0, 8'h00, 32'h0, 3'd0, 1'b0, "R11 app22 keeps cs");

    // short extra byte
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h00); push_n(8'hFF, 7);
    rxq.push_back(8'h00); rxq.push_back(8'h5A);
    run_cmd(6'd13, 32'h0, 1'b1, 2'd3, 8'h00, 32'h5A, 3'd0, 1'b1, "R8 short extra");

    // poll boundary: status on 16th poll, then one poll too late
    new_test(); push_n(8'hFF, 22); rxq.push_back(8'h00);
    run_cmd(6'd16, 32'h200, 1'b0, 2'd0, 8'h00, 32'h0, 3'd0, 1'b1, "R3 last poll");
    new_test(); push_n(8'hFF, 23); rxq.push_back(8'h00);
    run_cmd(6'd16, 32'h200, 1'b0, 2'd0, 8'hFF, 32'h0, 3'd1, 1'b1, "R3 poll too late");

    // timeouts
    new_test(); push_n(8'h00, 100);
    run_cmd(6'd16, 32'h200, 1'b0, 2'd0, 8'hFF, 32'h0, 3'd6, 1'b1, "R10 ready timeout");
    chk(count_tx(8'h50) == 0, "R10 no packet after timeout", count_tx(8'h50), 32'd0);
    new_test(); push_n(8'hFF, 7); rxq.push_back(8'h00); push_n(8'h00, 100);
    run_cmd(6'd38, 32'h0, 1'b0, 2'd1, 8'h00, 32'h0, 3'd6, 1'b1, "R9 R10 busy timeout");

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "scoreboard drained", expq.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule